// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional Access

This block sits between several processing elements and one shared word memory. Each element issues plain loads, plain stores, load-reserved and store-conditional requests. The monitor gives atomic read-modify-write behaviour without locking the interconnect. It keeps one reservation register per element, holding a word address and a valid flag. A load-reserved reads memory and records its address in that register. A store-conditional writes memory only if the issuer's reservation is still valid and matches the store address. It returns 1 on success and 0 on failure. Every write that reaches memory is compared against all reservations, and any reservation on the same address is dropped. A per-element context-switch input also drops that element's reservation.

Requests are granted one at a time by a fixed-priority arbiter, where a lower element index wins. Each request passes through a three-state machine. ST_IDLE arbitrates and latches the winner (transition IDLE→EXEC on any grant; it stays in IDLE otherwise). ST_EXEC drives the memory port, evaluates the reservation and updates the reservation registers (transition EXEC→RESP, always). ST_RESP returns the response to the owner (transition RESP→IDLE, always). Memory reads return data one cycle after the access.

Top module: `lrsc_monitor`

## Requirements
- R1: When several elements request in the same cycle, the lowest index is granted. `req_grant` is at most one-hot and is asserted only while the monitor is idle. A requester holds its request until it sees its grant.
- R2: A load (op code 0) returns the word stored at its address. `rsp_valid` for the owner is high for one cycle, two clock edges after the edge that accepts the grant.
- R3: A load-reserved (op code 2) returns memory data and records the full word address as a valid reservation of the issuer.
- R4: A store-conditional (op code 3) whose address equals the issuer's valid reservation writes its data to memory and responds with `rsp_data` = 1.
- R5: A store-conditional without a valid reservation, or with a different address, responds with 0 and issues no memory access, so memory keeps its old value.
- R6: Any committed write (a plain store or a successful store-conditional) from any element clears every reservation whose address equals the write address.
- R7: A high `ctx_clear` bit clears that element's reservation at the next edge, and it takes precedence over a reservation set in the same cycle. The element's next store-conditional then fails.
- R8: When two elements reserve the same address, the first store-conditional succeeds and the later one fails without writing.
- R9: A successful store-conditional also clears the issuer's own reservation, so a repeated store-conditional fails.
- R10: Address matching uses all address bits. A write to any other address, including one that differs only in upper bits, leaves a reservation intact.
- R11: After reset no reservation is valid, no grant or response is active and the memory port is idle.
- R12: A plain store (op code 1) writes memory and responds with `rsp_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_PE | Request pending, one bit per element |
| req_op | input | 2*NUM_PE | Op code per element: 0 load, 1 store, 2 load-reserved, 3 store-conditional |
| req_addr | input | ADDR_W*NUM_PE | Word address per element |
| req_wdata | input | DATA_W*NUM_PE | Store data per element |
| ctx_clear | input | NUM_PE | Context-switch reservation clear per element |
| req_grant | output | NUM_PE | One-hot grant, request accepted at this edge |
| rsp_valid | output | NUM_PE | One-hot response strobe to the owning element |
| rsp_data | output | DATA_W | Read data, or store-conditional result (1/0), or 0 for a store |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after a read access |

## Verification
A reservation that stays valid too long shows up as a store-conditional that returns 1 and overwrites data. This is visible at the owner's next store-conditional response and in the next load of that address. A reservation lost too early shows up as a spurious 0. A corrupted address in a reservation register behaves the same way and is exposed by matching and non-matching addresses, including ones that differ only in upper bits. A wrong arbitration or state sequence moves the response strobe off its fixed two-edge slot, so it is caught in the same request.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LR    = 2'd2,
        OP_SC    = 2'd3
    } lrsc_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_RESP = 2'd2
    } lrsc_state_e;
endpackage

// File: rtl/lrsc_arbiter.sv
module lrsc_arbiter #(
    parameter int NUM_PE = 4,
    localparam int IDX_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
    input  logic [NUM_PE-1:0] req,
    output logic [NUM_PE-1:0] gnt,
    output logic [IDX_W-1:0]  gnt_idx,
    output logic              gnt_any
);
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int i = 0; i < NUM_PE; i++) begin
            if (req[i] && !gnt_any) begin
                gnt[i]  = 1'b1;
                gnt_idx = IDX_W'(i);
                gnt_any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lrsc_link_file.sv
module lrsc_link_file #(
    parameter int NUM_PE = 4,
    parameter int ADDR_W = 16,
    localparam int IDX_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NUM_PE-1:0] ctx_clear,
    input  logic [IDX_W-1:0]  q_idx,
    input  logic [ADDR_W-1:0] q_addr,
    output logic              q_hit
);
    logic [NUM_PE-1:0] lnk_vld;
    logic [ADDR_W-1:0] lnk_addr [NUM_PE];

    for (genvar g = 0; g < NUM_PE; g++) begin : g_link
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lnk_vld[g]  <= 1'b0;
                lnk_addr[g] <= '0;
            end else if (ctx_clear[g]) begin
                lnk_vld[g] <= 1'b0;
            end else if (set_en && set_idx == IDX_W'(g)) begin
                lnk_vld[g]  <= 1'b1;
                lnk_addr[g] <= set_addr;
            end else if (wr_en && lnk_vld[g] && lnk_addr[g] == wr_addr) begin
                lnk_vld[g] <= 1'b0;
            end
        end

        // R7: context switch drops the reservation
        a_r7_ctx_clears: assert property (@(posedge clk) disable iff (!rst_n)
            ctx_clear[g] |=> !lnk_vld[g]);

        // R6: snooped write leaves no reservation on its address
        a_r6_snoop_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !set_en) |=> !(lnk_vld[g] && lnk_addr[g] == $past(wr_addr)));

        // R3: load-reserved records the address
        a_r3_reserve_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (set_en && set_idx == IDX_W'(g) && !ctx_clear[g])
            |=> (lnk_vld[g] && lnk_addr[g] == $past(set_addr)));
    end

    assign q_hit = lnk_vld[q_idx] && (lnk_addr[q_idx] == q_addr);
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
    import lrsc_pkg::*;
#(
    parameter int NUM_PE = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PE-1:0]          req_valid,
    input  logic [2*NUM_PE-1:0]        req_op,
    input  logic [ADDR_W*NUM_PE-1:0]   req_addr,
    input  logic [DATA_W*NUM_PE-1:0]   req_wdata,
    input  logic [NUM_PE-1:0]          ctx_clear,
    output logic [NUM_PE-1:0]          req_grant,
    output logic [NUM_PE-1:0]          rsp_valid,
    output logic [DATA_W-1:0]          rsp_data,
    output logic                       mem_en,
    output logic                       mem_we,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [DATA_W-1:0]          mem_wdata,
    input  logic [DATA_W-1:0]          mem_rdata
);
    lrsc_state_e       st_q, st_d;
    logic [IDX_W-1:0]  own_q;
    lrsc_op_e          op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              sc_ok_q;

    logic [NUM_PE-1:0] arb_req;
    logic [NUM_PE-1:0] arb_gnt;
    logic [IDX_W-1:0]  arb_idx;
    logic              arb_any;
    logic              link_hit;
    logic              exec_wr;

    assign arb_req = (st_q == ST_IDLE) ? req_valid : '0;

    lrsc_arbiter #(.NUM_PE(NUM_PE)) u_arb (
        .req     (arb_req),
        .gnt     (arb_gnt),
        .gnt_idx (arb_idx),
        .gnt_any (arb_any)
    );

    lrsc_link_file #(.NUM_PE(NUM_PE), .ADDR_W(ADDR_W)) u_links (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (st_q == ST_EXEC && op_q == OP_LR),
        .set_idx   (own_q),
        .set_addr  (addr_q),
        .wr_en     (exec_wr),
        .wr_addr   (addr_q),
        .ctx_clear (ctx_clear),
        .q_idx     (own_q),
        .q_addr    (addr_q),
        .q_hit     (link_hit)
    );

    assign exec_wr = (st_q == ST_EXEC) &&
                     (op_q == OP_STORE || (op_q == OP_SC && link_hit));

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (arb_any) st_d = ST_EXEC;
            ST_EXEC: st_d = ST_RESP;
            ST_RESP: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            own_q   <= '0;
            op_q    <= OP_LOAD;
            addr_q  <= '0;
            wdata_q <= '0;
            sc_ok_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && arb_any) begin
                own_q   <= arb_idx;
                op_q    <= lrsc_op_e'(req_op[arb_idx*2 +: 2]);
                addr_q  <= req_addr[arb_idx*ADDR_W +: ADDR_W];
                wdata_q <= req_wdata[arb_idx*DATA_W +: DATA_W];
            end
            if (st_q == ST_EXEC) sc_ok_q <= link_hit;
        end
    end

    // outputs
    always_comb begin
        req_grant = arb_gnt;
        rsp_valid = '0;
        rsp_data  = '0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        unique case (st_q)
            ST_IDLE: ;
            ST_EXEC: begin
                mem_en = (op_q != OP_SC) || link_hit;
                mem_we = exec_wr;
            end
            ST_RESP: begin
                rsp_valid[own_q] = 1'b1;
                if (op_q == OP_LOAD || op_q == OP_LR) rsp_data = mem_rdata;
                else if (op_q == OP_SC)                rsp_data = DATA_W'(sc_ok_q);
            end
            default: ;
        endcase
    end

    // R1: one grant at a time
    a_r1_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_grant));

    // R2: response two edges after the grant edge
    a_r2_resp_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant != '0) |=> ##1 (rsp_valid != '0));

    // R5: a failing store-conditional touches no memory
    a_r5_sc_fail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EXEC && op_q == OP_SC && !link_hit) |-> !mem_en);

    // R4: a reported success was preceded by a write
    a_r4_sc_ok_wrote: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid != '0 && op_q == OP_SC && rsp_data[0]) |-> $past(mem_we));

    // R11: memory idle while responding
    a_r11_resp_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid != '0) |-> !mem_en);
endmodule

// File: tb/tb_lrsc_monitor.sv
module tb_lrsc_monitor;
    localparam int N  = 4;
    localparam int AW = 16;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [2*N-1:0]  req_op = '0;
    logic [AW*N-1:0] req_addr = '0;
    logic [DW*N-1:0] req_wdata = '0;
    logic [N-1:0]    ctx_clear = '0;
    logic [N-1:0]    req_grant, rsp_valid;
    logic [DW-1:0]   rsp_data, mem_wdata, mem_rdata;
    logic            mem_en, mem_we;
    logic [AW-1:0]   mem_addr;
    logic [DW-1:0]   mem [256];

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    lrsc_monitor #(.NUM_PE(N), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .ctx_clear(ctx_clear),
        .req_grant(req_grant), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (mem_en && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_en && !mem_we) mem_rdata <= mem[mem_addr[7:0]];
    end

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // issue one request from element pe and return its response
    task automatic do_op(input int pe, input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output logic [DW-1:0] r);
        int n;
        @(negedge clk);
        req_op[pe*2 +: 2]     = op;
        req_addr[pe*AW +: AW] = a;
        req_wdata[pe*DW +: DW] = d;
        req_valid[pe]         = 1'b1;
        #1;
        n = 0;
        while (!req_grant[pe] && n < 20) begin
            @(negedge clk); #1; n++;
        end
        @(negedge clk);
        req_valid[pe] = 1'b0;
        n = 0;
        while (!rsp_valid[pe] && n < 20) begin
            @(negedge clk); n++;
        end
        chk(rsp_valid[pe], "R2 response strobe", DW'(rsp_valid), DW'(1 << pe));
        r = rsp_data;
    endtask

    task automatic t_reset();
        chk(rsp_valid == '0, "R11 rsp_valid after reset", DW'(rsp_valid), 0);
        chk(req_grant == '0, "R11 grant after reset", DW'(req_grant), 0);
        chk(!mem_en, "R11 mem_en after reset", DW'(mem_en), 0);
    endtask

    task automatic t_load_store();
        logic [DW-1:0] r;
        do_op(0, 2'd1, 16'h0010, 32'hAAAA_0001, r);
        chk(r == 0, "R12 store response", r, 0);
        do_op(0, 2'd0, 16'h0010, 0, r);
        chk(r == 32'hAAAA_0001, "R2 load data", r, 32'hAAAA_0001);
    endtask

    task automatic t_lr_sc_ok();
        logic [DW-1:0] r;
        do_op(1, 2'd2, 16'h0010, 0, r);
        chk(r == 32'hAAAA_0001, "R3 lr data", r, 32'hAAAA_0001);
        do_op(1, 2'd3, 16'h0010, 32'hBBBB_0002, r);
        chk(r == 1, "R4 sc success", r, 1);
        do_op(0, 2'd0, 16'h0010, 0, r);
        chk(r == 32'hBBBB_0002, "R4 sc wrote", r, 32'hBBBB_0002);
        do_op(1, 2'd3, 16'h0010, 32'hCCCC_0003, r);
        chk(r == 0, "R9 repeated sc fails", r, 0);
        do_op(0, 2'd0, 16'h0010, 0, r);
        chk(r == 32'hBBBB_0002, "R9 repeated sc no write", r, 32'hBBBB_0002);
    endtask

    task automatic t_sc_fail();
        logic [DW-1:0] r;
        do_op(2, 2'd3, 16'h0020, 32'h1111_1111, r);
        chk(r == 0, "R5 sc without lr", r, 0);
        do_op(2, 2'd2, 16'h0020, 0, r);
        do_op(2, 2'd3, 16'h0021, 32'h2222_2222, r);
        chk(r == 0, "R5 sc other address", r, 0);
        do_op(0, 2'd0, 16'h0021, 0, r);
        chk(r == 0, "R5 memory unchanged", r, 0);
        do_op(0, 2'd0, 16'h0020, 0, r);
        chk(r == 0, "R5 memory unchanged at 0x20", r, 0);
    endtask

    task automatic t_two_reservers();
        logic [DW-1:0] r;
        do_op(0, 2'd2, 16'h0030, 0, r);
        do_op(3, 2'd2, 16'h0030, 0, r);
        do_op(3, 2'd3, 16'h0030, 32'h3333_0003, r);
        chk(r == 1, "R8 first sc succeeds", r, 1);
        do_op(0, 2'd3, 16'h0030, 32'h0000_DEAD, r);
        chk(r == 0, "R8 second sc fails", r, 0);
        do_op(1, 2'd0, 16'h0030, 0, r);
        chk(r == 32'h3333_0003, "R8 data from first sc", r, 32'h3333_0003);
    endtask

    task automatic t_snoop();
        logic [DW-1:0] r;
        do_op(1, 2'd2, 16'h0040, 0, r);
        do_op(2, 2'd1, 16'h0040, 32'h4444_0004, r);
        do_op(1, 2'd3, 16'h0040, 32'h5555_0005, r);
        chk(r == 0, "R6 store by other clears", r, 0);
        do_op(0, 2'd0, 16'h0040, 0, r);
        chk(r == 32'h4444_0004, "R6 failed sc kept store", r, 32'h4444_0004);
    endtask

    task automatic t_other_addr();
        logic [DW-1:0] r;
        do_op(1, 2'd2, 16'h0050, 0, r);
        do_op(2, 2'd1, 16'h0051, 32'h6666_0006, r);
        do_op(2, 2'd1, 16'h0150, 32'h7777_0007, r);
        do_op(1, 2'd3, 16'h0050, 32'h8888_0008, r);
        chk(r == 1, "R10 upper-bit alias keeps reservation", r, 1);
    endtask

    task automatic t_ctx();
        logic [DW-1:0] r;
        do_op(2, 2'd2, 16'h0060, 0, r);
        @(negedge clk); ctx_clear[2] = 1'b1;
        @(negedge clk); ctx_clear[2] = 1'b0;
        do_op(2, 2'd3, 16'h0060, 32'h9999_0009, r);
        chk(r == 0, "R7 context switch clears", r, 0);
    endtask

    task automatic t_priority();
        int n;
        @(negedge clk);
        req_op[0 +: 2]   = 2'd0; req_addr[0 +: AW] = 16'h0010;
        req_op[4 +: 2]   = 2'd0; req_addr[2*AW +: AW] = 16'h0030;
        req_valid = 4'b0101;
        #1;
        chk(req_grant == 4'b0001, "R1 low index wins", DW'(req_grant), 1);
        @(negedge clk); req_valid[0] = 1'b0;
        #1;
        chk(req_grant == 4'b0000, "R1 no grant while busy", DW'(req_grant), 0);
        @(negedge clk);
        chk(rsp_valid == 4'b0001 && rsp_data == 32'hBBBB_0002, "R1 first response",
            rsp_data, 32'hBBBB_0002);
        n = 0;
        while (!req_grant[2] && n < 10) begin
            @(negedge clk); #1; n++;
        end
        @(negedge clk); req_valid[2] = 1'b0;
        @(negedge clk);
        chk(rsp_valid == 4'b0100 && rsp_data == 32'h3333_0003, "R1 second response",
            rsp_data, 32'h3333_0003);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_store();
        t_lr_sc_ok();
        t_sc_fail();
        t_two_reservers();
        t_snoop();
        t_other_addr();
        t_ctx();
        t_priority();
        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        finish_run();
    end
endmodule